// File: doc/BRIEF.md
# ISA Capability Register Legalizer

This block holds the writable register that tells the rest of a hart which base width it has and which extension letters are turned on. The register has two parts. A 2-bit base-width field sits in the top two bits. A 26-bit extension map sits in the low bits, with one bit per letter: A is bit 0 and Z is bit 25.

Software proposes a new value by pulsing a write strobe. The block does not store that value as it is. It first decides whether to keep the write at all, and then trims the value until it is legal, applying the rules in a fixed order:

1. The write is discarded outright when it names neither the I base nor the E base.
2. The write is discarded outright when it names the E base.
3. Otherwise the value is masked by the hart's static supported-letter mask and by the set of letters this design implements.
4. Double-precision float is dropped when single-precision float is not present.
5. Compressed is dropped when the next instruction address is not a multiple of four.

The base-width field never takes a written value. When a kept write changes the stored value, a one-cycle flush pulse tells fetch and decode to discard state that was built under the old extensions. A static parameter can make the register read-only.

Top module: `isa_cap_reg`

## Requirements
- R1: After reset, `cap_value` reads `{RESET_MXL, 4'b0000, RESET_EXT}`, which is 32'h4014_112D by default, and `flush` is 0.
- R2: A strobed write whose data has neither bit 8 (I) nor bit 4 (E) set is dropped: `cap_value` is unchanged on the next cycle and `flush` stays 0.
- R3: A strobed write whose data has bit 4 (E) set is dropped, whatever else it holds: `cap_value` is unchanged and `flush` stays 0.
- R4: A kept write stores `wr_data[25:0] & hart_ext_mask & IMPL`, after R5 and R6 are applied. IMPL is the set of letters A, C, D, E, F, I, M, S and U, at bits 0, 2, 3, 4, 5, 8, 12, 18 and 20. Bits 29:26 always read 0.
- R5: If, after masking, bit 3 (D) is set and bit 5 (F) is clear, bit 3 is stored as 0.
- R6: If, after masking, bit 2 (C) is set and `next_pc[1:0]` is not 0, bit 2 is stored as 0. When `next_pc[1:0]` is 0, C is kept.
- R7: Bits 31:30 (the base width) keep their reset value through every write.
- R8: `flush` is 1 for exactly the one cycle after a kept write whose stored result differs from the previous `cap_value`. It is 0 otherwise, including for a kept write that leaves the value the same.
- R9: With `WRITABLE` = 0, every write is ignored: `cap_value` stays at its reset value and `flush` stays 0.
- R10: A kept write becomes visible on `cap_value` at the first rising clock edge after the strobe. With `wr_en` low, `cap_value` never changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe, one proposed value per cycle |
| wr_data | input | 32 | Proposed register value |
| hart_ext_mask | input | 26 | Static per-hart supported-letter mask, bit 0 = A |
| next_pc | input | 32 | Address of the next instruction, used for the C rule |
| cap_value | output | 32 | Current register value |
| flush | output | 1 | One-cycle pulse after a kept write that changed the value |

## Verification
Two things can happen together on one write: the D-without-F rule and the misaligned-C rule. Both can apply to the same proposed value. The bench builds writes that set D without F and also carry a misaligned `next_pc`, so both bits must be cleared in one step, and it checks the stored value and the flush decision against its own model.

The random writes set D, F and C independently and draw the low bits of `next_pc` at random, so many cycles exercise both rules at once. Each result is judged against the model's legalized value. The flush decision is judged on whether that value differs from the previous one, since the two trims together can turn an apparent change into no change.

// File: rtl/isa_cap_reg.sv
module isa_cap_reg #(
  parameter int          XLEN      = 32,
  parameter int          EXT_W     = 26,
  parameter int          WRITABLE  = 1,
  parameter logic [1:0]  RESET_MXL = 2'b01,
  parameter logic [25:0] RESET_EXT = 26'h014112D
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [XLEN-1:0]  wr_data,
  input  logic [EXT_W-1:0] hart_ext_mask,
  input  logic [XLEN-1:0]  next_pc,
  output logic [XLEN-1:0]  cap_value,
  output logic             flush
);
  localparam int BIT_A = 0;
  localparam int BIT_C = 2;
  localparam int BIT_D = 3;
  localparam int BIT_E = 4;
  localparam int BIT_F = 5;
  localparam int BIT_I = 8;
  localparam int BIT_M = 12;
  localparam int BIT_S = 18;
  localparam int BIT_U = 20;
  localparam int PAD_W = XLEN - EXT_W - 2;
  localparam logic [EXT_W-1:0] ONE = {{(EXT_W-1){1'b0}}, 1'b1};
  localparam logic [EXT_W-1:0] IMPL =
    (ONE << BIT_A) | (ONE << BIT_C) | (ONE << BIT_D) | (ONE << BIT_E) |
    (ONE << BIT_F) | (ONE << BIT_I) | (ONE << BIT_M) | (ONE << BIT_S) |
    (ONE << BIT_U);
  localparam bit CAN_WRITE = (WRITABLE != 0);

  logic [1:0]       mxl_q;
  logic [EXT_W-1:0] ext_q;
  logic [EXT_W-1:0] proposed;
  logic [EXT_W-1:0] legal;
  logic             accept;
  logic             unused_bits;

  assign proposed    = wr_data[EXT_W-1:0];
  assign accept      = CAN_WRITE && wr_en && (proposed[BIT_I] || proposed[BIT_E]) && !proposed[BIT_E];
  assign cap_value   = {mxl_q, {PAD_W{1'b0}}, ext_q};
  assign unused_bits = ^{wr_data[XLEN-1:EXT_W], next_pc[XLEN-1:2]};

  always_comb begin
    legal = proposed & hart_ext_mask & IMPL;
    if (legal[BIT_D] && !legal[BIT_F]) legal[BIT_D] = 1'b0;
    if (legal[BIT_C] && (next_pc[1:0] != 2'b00)) legal[BIT_C] = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mxl_q <= RESET_MXL;
      ext_q <= RESET_EXT;
      flush <= 1'b0;
    end else begin
      flush <= accept && (legal != ext_q);
      if (accept) ext_q <= legal;
    end
  end

  AST_NO_STROBE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(cap_value)); // R10
  AST_NO_BASE_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && !wr_data[BIT_I] && !wr_data[BIT_E] |=> $stable(cap_value) && !flush); // R2
  AST_E_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && wr_data[BIT_E] |=> $stable(cap_value) && !flush); // R3
  AST_BASE_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
    cap_value[XLEN-1:XLEN-2] == RESET_MXL); // R7
  AST_PAD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    cap_value[XLEN-3:EXT_W] == '0); // R4
  AST_D_NEEDS_F: assert property (@(posedge clk) disable iff (!rst_n)
    flush |-> !(cap_value[BIT_D] && !cap_value[BIT_F])); // R5
  AST_FLUSH_CHANGED: assert property (@(posedge clk) disable iff (!rst_n)
    flush |-> cap_value != $past(cap_value)); // R8

  generate
    if (!CAN_WRITE) begin : g_locked
      AST_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> $stable(cap_value) && !flush); // R9
    end
  endgenerate
endmodule

// File: tb/sim_isa_cap_reg.sv
module sim_isa_cap_reg;
  localparam logic [31:0] RST_VAL = 32'h4014_112D;
  localparam logic [25:0] IMPL    = 26'h014113D;
  localparam logic [25:0] FULL    = {26{1'b1}};

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic [25:0] hart_ext_mask = FULL;
  logic [31:0] next_pc = '0;
  logic [31:0] cap_value, cap_lock;
  logic        flush, flush_lock;

  int n_checks = 0;
  int n_fail = 0;
  logic [31:0] model = RST_VAL;
  logic        model_flush = 1'b0;

  always #10 clk = ~clk;

  isa_cap_reg u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .hart_ext_mask(hart_ext_mask), .next_pc(next_pc),
    .cap_value(cap_value), .flush(flush));

  isa_cap_reg #(.WRITABLE(0)) u1 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .hart_ext_mask(hart_ext_mask), .next_pc(next_pc),
    .cap_value(cap_lock), .flush(flush_lock));

  function automatic logic [31:0] legalize(input logic [31:0] old, input logic [31:0] d,
                                           input logic [25:0] m, input logic [31:0] pc);
    logic [25:0] e;
    if (!(d[8] || d[4]) || d[4]) return old;
    e = d[25:0] & m & IMPL;
    if (e[3] && !e[5]) e[3] = 1'b0;
    if (e[2] && pc[1:0] != 2'b00) e[2] = 1'b0;
    return {old[31:30], 4'b0000, e};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  task automatic step(input logic en, input logic [31:0] d, input logic [31:0] pc, input string req);
    logic [31:0] nxt;
    wr_en = en; wr_data = d; next_pc = pc;
    nxt = en ? legalize(model, d, hart_ext_mask, pc) : model;
    model_flush = (nxt != model);
    model = nxt;
    @(negedge clk);
    chk(req, cap_value, model);
    chk({req, " flush R8"}, {31'b0, flush}, {31'b0, model_flush});
    chk("R9 locked value", cap_lock, RST_VAL);
    chk("R9 locked flush", {31'b0, flush_lock}, 32'b0);
    chk("R7 base", {30'b0, cap_value[31:30]}, 32'h1);
    wr_en = 1'b0;
  endtask

  initial begin
    #(20 * 150000);
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("%0d/%0d checks passed", n_checks + 1 - n_fail, n_checks + 1);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_1234));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    chk("R1 reset value", cap_value, RST_VAL);
    chk("R1 reset flush", {31'b0, flush}, 32'b0);
    step(1'b1, 32'h0000_0100, 32'h0, "R4 I only");
    step(1'b1, 32'h0000_0100, 32'h0, "R8 same value again");
    step(1'b0, 32'h0000_0000, 32'h0, "R8 flush falls");
    step(1'b1, 32'h0000_0134, 32'h0, "R3 E set dropped");
    step(1'b1, 32'h0014_102D, 32'h0, "R2 no base dropped");
    step(1'b1, 32'h0000_010C, 32'h2, "R5 R6 D and C trimmed together");
    step(1'b1, 32'h0000_012C, 32'h4, "R6 aligned keeps C");
    step(1'b1, 32'h0000_012C, 32'h1, "R6 misaligned drops C");
    step(1'b1, 32'hC000_0108, 32'h0, "R5 D without F");
    step(1'b1, 32'hFFFF_FFEF, 32'h0, "R7 R4 all letters but E");
    step(1'b0, 32'h0000_0100, 32'h0, "R10 no strobe");
    hart_ext_mask = FULL & ~(26'h1 << 12) & ~(26'h1 << 5);
    step(1'b1, 32'h0014_112D, 32'h8, "R4 R5 hart mask lacks M and F");
    hart_ext_mask = FULL;
    for (int i = 0; i < 3000; i++) begin
      logic [31:0] d, pc;
      d = $urandom;
      d[8] = ($urandom_range(3) != 0);
      d[4] = ($urandom_range(7) == 0);
      pc = $urandom;
      if ($urandom_range(7) == 0) hart_ext_mask = $urandom;
      else if ($urandom_range(7) == 0) hart_ext_mask = FULL;
      step($urandom_range(4) != 0, d, pc, "R4 R10 random write");
    end
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule